// File: doc/BRIEF.md
# One-Bit Serial Register Port

This block lets a host reach a wide control word and a status word through a single data line. Each host access is framed by an active-low chip select. A companion address line and a read/write line qualify it. A write access moves one data bit into a staging shift register. A separate access with the address line high copies the whole staged word into the live control register. The parallel fields that steer the rest of the chip come from the live control register only.

Reads use the same framing with the read/write line high. The first read after a reset or a commit captures the status word. Each read access then presents one status bit on the data line, starting with bit 0. The data output is enabled only while a read access is in progress, so a pad buffer can place it on a shared line.

All strobes are asynchronous to the system clock. They pass through a synchronizer and an edge detector, and every effect is timed from a synchronized chip-select edge. The system reset is synchronous and active low. It restores the control register to its default value and disables the data output.

Top module: `serial_reg_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ctrl_word` takes `CTRL_DEFAULT` (default 47'h11) and `dout_oe` and `dout` are 0 after that edge.
- R2: An access with `addr`=0 and `rd_wr`=0 shifts `din` into the staging register at the chip-select rising edge. The new bit enters at bit `CTRL_W-1` and the register moves toward bit 0, so the first of 47 bits written ends at bit 0.
- R3: An access with `addr`=1 copies the staging register into `ctrl_word` at the chip-select falling edge. This is the only way `ctrl_word` changes outside reset.
- R4: `in_sel` is `ctrl_word[1:0]`, `fmt_sel` is `ctrl_word[3:2]`, and `clamp_en` is `ctrl_word[4]`.
- R5: The first read access (`addr`=0, `rd_wr`=1) after a reset or a commit loads `status_in`. That access and the ones after it show status bits 0, 1, 2 and so on, one per access, and zeros once the word is used up. A change of `status_in` between reads is not seen until a commit re-arms the load.
- R6: `dout_oe` is 1 only during a read access, from the synchronized chip-select fall to the synchronized rise. `dout` is 0 whenever `dout_oe` is 0. With chip select high, activity on `din`, `addr` and `rd_wr` changes no output.
- R7: With `SYNC_STAGES`=2, an output changes at the third rising clock edge after the chip-select change is first presented to the block.
- R8: A write sequence of fewer than 47 bits, followed by a commit, loads the staging contents as shifted: earlier bits move down and later bits sit at the top. Writes without a commit leave `ctrl_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low access strobe, asynchronous |
| addr | input | 1 | 0: data shift access, 1: commit access |
| rd_wr | input | 1 | 1: read, 0: write (with `addr`=0) |
| din | input | 1 | Serial data in from the host |
| status_in | input | STAT_W | Status word offered for reading |
| dout | output | 1 | Serial data out to the host |
| dout_oe | output | 1 | Output enable for the data pad buffer |
| ctrl_word | output | CTRL_W | Live control register |
| in_sel | output | 2 | Video input channel select field |
| fmt_sel | output | 2 | Line standard / format select field |
| clamp_en | output | 1 | Back-porch clamp enable field |

## Verification
The bench builds the block with `CTRL_W`=47, `STAT_W`=16, `SYNC_STAGES`=2 and a default control word of 47'h11. Because the status word is shorter than the control word, a run of twenty reads passes the end of the status word and reaches the zero-fill case. The full 47-bit length lets both a complete word and a 5-bit partial write be committed, so the exact shifted placement of partial writes can be checked. The two-stage synchronizer fixes a three-edge latency, which the bench checks one edge at a time around a commit.

// File: rtl/serport_pkg.sv
// Package: shared field positions and the strobe bundle for the serial register port.
// Assumes control words are at least 5 bits wide so all named fields exist.
package serport_pkg;

    localparam int IN_SEL_LSB = 0;
    localparam int IN_SEL_W   = 2;
    localparam int FMT_LSB    = 2;
    localparam int FMT_W      = 2;
    localparam int CLAMP_BIT  = 4;
    localparam int MIN_CTRL_W = CLAMP_BIT + 1;

    typedef struct packed {
        logic cs_n;
        logic addr;
        logic rd_wr;
        logic din;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, addr: 1'b0, rd_wr: 1'b0, din: 1'b0};

endpackage

// File: rtl/serport_strobe_sync.sv
// Module: brings the four host strobes into the clock domain and detects chip-select edges.
// Assumes addr, rd_wr and din are held stable for the whole time chip select is low,
// so all four bits cross together through the same number of stages.
module serport_strobe_sync
    import serport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t raw_in,
    output strobe_t sync_out,
    output logic    cs_fall,
    output logic    cs_rise
);

    strobe_t [STAGES-1:0] chain_q;
    logic                 cs_n_prev_q;

    // Synchronizer chain: stage 0 samples the raw pins, later stages retime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{STROBE_IDLE}};
        end else begin
            chain_q[0] <= raw_in;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Edge history: keeps the last synchronized chip-select level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n_prev_q <= 1'b1;
        end else begin
            cs_n_prev_q <= chain_q[STAGES-1].cs_n;
        end
    end

    assign sync_out = chain_q[STAGES-1];
    assign cs_fall  = cs_n_prev_q & ~sync_out.cs_n;
    assign cs_rise  = ~cs_n_prev_q & sync_out.cs_n;

endmodule

// File: rtl/serport_ctrl_stage.sv
// Module: staging shift register plus the live control register it commits into.
// Assumes shift_en and commit are never high in the same cycle (they come from
// opposite chip-select edges).
module serport_ctrl_stage #(
    parameter int                CTRL_W       = 47,
    parameter logic [CTRL_W-1:0] CTRL_DEFAULT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              commit,
    output logic [CTRL_W-1:0] ctrl_q
);

    logic [CTRL_W-1:0] stage_q;

    // Staging register: new bit enters at the top, the word moves toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            stage_q <= {bit_in, stage_q[CTRL_W-1:1]};
        end
    end

    // Live control register: takes the staged word only on a commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_DEFAULT;
        end else if (commit) begin
            ctrl_q <= stage_q;
        end
    end

endmodule

// File: rtl/serport_stat_shift.sv
// Module: status read shifter and data-output enable.
// Assumes rd_start and rearm are exclusive, and rd_step and rd_start are exclusive.
module serport_stat_shift #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              rd_step,
    input  logic              acc_end,
    input  logic              rearm,
    input  logic [STAT_W-1:0] status_in,
    output logic              dout,
    output logic              dout_oe
);

    logic [STAT_W-1:0] sr_q;
    logic              fresh_q;
    logic              oe_q;

    // Read shifter: captures status on an armed read, drops one bit per read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (rd_start && fresh_q) begin
            sr_q <= status_in;
        end else if (rd_step) begin
            sr_q <= sr_q >> 1;
        end
    end

    // Load arm flag: set by reset or commit, cleared by the capturing read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
        end else if (rearm) begin
            fresh_q <= 1'b1;
        end else if (rd_start) begin
            fresh_q <= 1'b0;
        end
    end

    // Output enable: open for the span of a read access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (rd_start) begin
            oe_q <= 1'b1;
        end else if (acc_end) begin
            oe_q <= 1'b0;
        end
    end

    assign dout    = oe_q & sr_q[0];
    assign dout_oe = oe_q;

endmodule

// File: rtl/serial_reg_port.sv
// Module: top of the one-bit host register port.
// Decodes each synchronized chip-select access into shift, commit or read actions.
// Assumes the host holds addr, rd_wr and din steady while cs_n is low.
module serial_reg_port
    import serport_pkg::*;
#(
    parameter int                CTRL_W       = 47,
    parameter int                STAT_W       = 16,
    parameter int                SYNC_STAGES  = 2,
    parameter logic [CTRL_W-1:0] CTRL_DEFAULT = 47'h11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              addr,
    input  logic              rd_wr,
    input  logic              din,
    input  logic [STAT_W-1:0] status_in,
    output logic              dout,
    output logic              dout_oe,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [1:0]        in_sel,
    output logic [1:0]        fmt_sel,
    output logic              clamp_en
);

    strobe_t raw_s;
    strobe_t syn_s;
    logic    cs_fall;
    logic    cs_rise;
    logic    is_wr;
    logic    is_rd;

    assign raw_s = '{cs_n: cs_n, addr: addr, rd_wr: rd_wr, din: din};

    serport_strobe_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_s),
        .sync_out (syn_s),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise)
    );

    // Access decode: shift and read accesses share addr=0, split by rd_wr.
    always_comb begin
        is_wr = ~syn_s.addr & ~syn_s.rd_wr;
        is_rd = ~syn_s.addr &  syn_s.rd_wr;
    end

    serport_ctrl_stage #(
        .CTRL_W       (CTRL_W),
        .CTRL_DEFAULT (CTRL_DEFAULT)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cs_rise & is_wr),
        .bit_in   (syn_s.din),
        .commit   (cs_fall & syn_s.addr),
        .ctrl_q   (ctrl_word)
    );

    serport_stat_shift #(
        .STAT_W (STAT_W)
    ) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (cs_fall & is_rd),
        .rd_step   (cs_rise & is_rd),
        .acc_end   (cs_rise),
        .rearm     (cs_fall & syn_s.addr),
        .status_in (status_in),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

    assign in_sel   = ctrl_word[IN_SEL_LSB +: IN_SEL_W];
    assign fmt_sel  = ctrl_word[FMT_LSB +: FMT_W];
    assign clamp_en = ctrl_word[CLAMP_BIT];

endmodule

// File: rtl/serport_checker.sv
// Module: temporal checks on the serial register port, attached by bind.
// Assumes the default two-stage synchronizer, so pin-to-effect delay is three edges.
module serport_checker #(
    parameter int                CTRL_W       = 47,
    parameter logic [CTRL_W-1:0] CTRL_DEFAULT = 47'h11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              addr,
    input logic              rd_wr,
    input logic              dout_oe,
    input logic [CTRL_W-1:0] ctrl_word
);

    logic [2:0] since_rst_q;
    logic       armed;

    // Cycle counter since reset release, saturating, gates history lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst_q <= '0;
        end else if (since_rst_q != 3'd7) begin
            since_rst_q <= since_rst_q + 3'd1;
        end
    end

    assign armed = (since_rst_q >= 3'd5);

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        !rst_n |=> (ctrl_word == CTRL_DEFAULT && !dout_oe)); // R1

    AST_CTRL_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$stable(ctrl_word)) |->
            ($past(addr, 3) && !$past(cs_n, 3) && $past(cs_n, 4))); // R3

    AST_OE_OPENS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(dout_oe)) |->
            (!$past(cs_n, 3) && $past(rd_wr, 3) && !$past(addr, 3))); // R6

    AST_OE_CLOSES_ON_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(dout_oe)) |-> $past(cs_n, 3)); // R6

    AST_LATENCY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(cs_n, 2) && !$past(cs_n, 1) && $past(addr, 1)) |=>
            $stable(ctrl_word)); // R7

endmodule

bind serial_reg_port serport_checker #(
    .CTRL_W       (CTRL_W),
    .CTRL_DEFAULT (CTRL_DEFAULT)
) u_serport_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .addr      (addr),
    .rd_wr     (rd_wr),
    .dout_oe   (dout_oe),
    .ctrl_word (ctrl_word)
);

// File: tb/test_serial_reg_port.sv
module test_serial_reg_port;

    localparam int           CLK_PERIOD = 10;
    localparam int           CW         = 47;
    localparam int           SW         = 16;
    localparam logic [CW-1:0] DEF       = 47'h11;
    localparam int           HOLD       = 5;
    localparam int           WATCHDOG   = 50000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          addr = 1'b0;
    logic          rd_wr = 1'b0;
    logic          din = 1'b0;
    logic [SW-1:0] status_in = '0;
    logic          dout;
    logic          dout_oe;
    logic [CW-1:0] ctrl_word;
    logic [1:0]    in_sel;
    logic [1:0]    fmt_sel;
    logic          clamp_en;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    serial_reg_port #(
        .CTRL_W       (CW),
        .STAT_W       (SW),
        .SYNC_STAGES  (2),
        .CTRL_DEFAULT (DEF)
    ) i_serial_reg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .addr      (addr),
        .rd_wr     (rd_wr),
        .din       (din),
        .status_in (status_in),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .ctrl_word (ctrl_word),
        .in_sel    (in_sel),
        .fmt_sel   (fmt_sel),
        .clamp_en  (clamp_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: pin history queue {cs,addr,rw,din}, two-edge crossing delay.
    bit [3:0]      hist[$] = '{4'h8, 4'h8, 4'h8, 4'h8};
    bit [CW-1:0]   m_stage = '0;
    bit [CW-1:0]   m_ctrl  = DEF;
    bit [SW-1:0]   m_rd    = '0;
    bit            m_fresh = 1'b1;
    bit            m_oe    = 1'b0;

    always @(posedge clk) begin
        bit [3:0] s;
        bit [3:0] p;
        if (!rst_n) begin
            hist    = '{4'h8, 4'h8, 4'h8, 4'h8};
            m_stage = '0;
            m_ctrl  = DEF;
            m_rd    = '0;
            m_fresh = 1'b1;
            m_oe    = 1'b0;
        end else begin
            s = hist[1];
            p = hist[2];
            if (p[3] && !s[3]) begin
                if (s[2]) begin
                    m_ctrl  = m_stage;
                    m_fresh = 1'b1;
                end else if (s[1]) begin
                    if (m_fresh) begin
                        m_rd    = status_in;
                        m_fresh = 1'b0;
                    end
                    m_oe = 1'b1;
                end
            end else if (!p[3] && s[3]) begin
                if (!s[2] && !s[1]) m_stage = {s[0], m_stage[CW-1:1]};
                if (!s[2] && s[1])  m_rd = m_rd >> 1;
                m_oe = 1'b0;
            end
            hist.push_front({cs_n, addr, rd_wr, din});
            void'(hist.pop_back());
        end
    end

    // Clock-by-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        vectors++;
        if (ctrl_word !== m_ctrl) begin
            fails++;
            $display("FAIL R3 ctrl_word actual=%h expected=%h t=%0t", ctrl_word, m_ctrl, $time);
        end
        if (in_sel !== m_ctrl[1:0] || fmt_sel !== m_ctrl[3:2] || clamp_en !== m_ctrl[4]) begin
            fails++;
            $display("FAIL R4 fields actual=%b_%b_%b expected=%b_%b_%b", in_sel, fmt_sel, clamp_en,
                     m_ctrl[1:0], m_ctrl[3:2], m_ctrl[4]);
        end
        if (dout_oe !== m_oe) begin
            fails++;
            $display("FAIL R6 dout_oe actual=%b expected=%b t=%0t", dout_oe, m_oe, $time);
        end
        if (dout !== (m_oe & m_rd[0])) begin
            fails++;
            $display("FAIL R5 dout actual=%b expected=%b t=%0t", dout, m_oe & m_rd[0], $time);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL R7 watchdog actual=%0d cycles expected=<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One framed host access; returns dout sampled late in the low phase.
    task automatic access(input bit a, input bit rw, input bit d, output bit got);
        @(negedge clk);
        addr = a; rd_wr = rw; din = d; cs_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        got = dout;
        if (a || !rw) chk(dout_oe == 1'b0, "R6 oe off in non-read", dout_oe, 0);
        else          chk(dout_oe == 1'b1, "R6 oe on in read", dout_oe, 1);
        cs_n = 1'b1;
        repeat (HOLD) @(negedge clk);
        chk(dout_oe == 1'b0, "R6 oe off after access", dout_oe, 0);
    endtask

    task automatic write_bits(input logic [CW-1:0] w, input int n);
        bit g;
        for (int i = 0; i < n; i++) access(1'b0, 1'b0, w[i], g);
    endtask

    initial begin
        bit                g;
        logic [CW-1:0]     w1;
        logic [CW-1:0]     w2;
        logic [SW-1:0]     s1;
        logic [SW-1:0]     s2;
        logic [CW-1:0]     exp_part;
        w1 = 47'h5A3C_9E17_2B46;
        w2 = 47'h2D0F_61B8_C3A9;
        s1 = 16'hB5C3;
        s2 = 16'h6E19;

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(ctrl_word == DEF, "R1 ctrl default", ctrl_word, DEF);
        chk(dout_oe == 1'b0 && dout == 1'b0, "R1 output disabled", {dout_oe, dout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2/R8: full write without commit leaves control untouched
        write_bits(w1, CW);
        chk(ctrl_word == DEF, "R8 no commit no change", ctrl_word, DEF);
        // R3: commit loads the staged word, LSB-first order per R2
        access(1'b1, 1'b0, 1'b0, g);
        chk(ctrl_word == w1, "R2 R3 commit word", ctrl_word, w1);
        chk(in_sel == w1[1:0] && fmt_sel == w1[3:2] && clamp_en == w1[4], "R4 field decode",
            {in_sel, fmt_sel, clamp_en}, {w1[1:0], w1[3:2], w1[4]});

        // R7: commit latency, one edge at a time
        write_bits(w2, CW);
        @(negedge clk);
        addr = 1'b1; rd_wr = 1'b0; cs_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ctrl_word == w1, "R7 unchanged after two edges", ctrl_word, w1);
        @(negedge clk);
        chk(ctrl_word == w2, "R7 changed at third edge", ctrl_word, w2);
        repeat (HOLD) @(negedge clk);
        cs_n = 1'b1;
        repeat (HOLD) @(negedge clk);

        // R5: twenty reads after a commit return status LSB first, then zeros
        status_in = s1;
        for (int i = 0; i < 20; i++) begin
            access(1'b0, 1'b1, 1'b0, g);
            chk(g == ((i < SW) ? s1[i] : 1'b0), $sformatf("R5 read bit %0d", i), g,
                (i < SW) ? s1[i] : 1'b0);
        end
        // R5: new status is not seen without a re-arming commit
        status_in = s2;
        access(1'b0, 1'b1, 1'b0, g);
        chk(g == 1'b0, "R5 no reload without commit", g, 0);

        // R6: strobe activity with chip select high changes nothing
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            din = i[0]; addr = i[1]; rd_wr = i[2];
        end
        repeat (4) @(negedge clk);
        chk(ctrl_word == w2, "R6 idle strobes ignored", ctrl_word, w2);
        chk(dout_oe == 1'b0, "R6 idle oe off", dout_oe, 0);

        // R8: five-bit partial write then commit
        write_bits(47'h16, 5);
        access(1'b1, 1'b0, 1'b0, g);
        exp_part = (w2 >> 5) | (47'(5'h16) << (CW - 5));
        chk(ctrl_word == exp_part, "R8 partial commit", ctrl_word, exp_part);

        // R5: commit re-arms the load, so the new status appears
        for (int i = 0; i < 4; i++) begin
            access(1'b0, 1'b1, 1'b0, g);
            chk(g == s2[i], $sformatf("R5 rearmed bit %0d", i), g, s2[i]);
        end

        // R1: reset in mid-read restores default and closes the output
        @(negedge clk);
        addr = 1'b0; rd_wr = 1'b1; cs_n = 1'b0;
        repeat (HOLD) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ctrl_word == DEF, "R1 reset restores default", ctrl_word, DEF);
        chk(dout_oe == 1'b0, "R1 reset closes output", dout_oe, 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule